// File: doc/BRIEF.md
# Posted-Write and Prefetch Bridge Buffer

This block sits between a fast host bus and a slower target bus. It holds two queues. One queue keeps posted writes, and each entry carries an address and its data. The other queue keeps read data that the target has returned ahead of the host consuming it. The host's write finishes as soon as the write queue takes it, so the host never sees target wait states. The target side drains writes in order through a valid/ready handshake.

On top of the two queues the block applies ordering and error rules:

- **Read ordering.** A host read request only goes through to the target once every posted write has drained. This keeps a read from overtaking an earlier write.
- **Write errors.** The target may report an error on a write it is completing, even though the host finished that write long before. Such an error sets a sticky interrupt, which stays up until the host clears it.
- **Read abort.** The host may abort a read whose data has already been prefetched. The abort empties the read data queue in a single cycle, so no stale words remain when the next read starts.

Both sides use one clock. The bus front ends and arbitration live outside this block.

Top module: `pwb_bridge_buf`

## Requirements
- R1: After reset:
  - `hw_ready` is 1 and `tr_rsp_ready` is 1.
  - `tw_valid`, `hd_valid` and `irq` are 0.
  - `tr_req_valid` is 0 while `hr_valid` is 0.
- R2: The write queue accepts a host write whenever `hw_valid` and `hw_ready` are both high. `hw_ready` stays high while fewer than `WQ_DEPTH` entries are queued, whatever `tw_ready` does. `WQ_DEPTH` writes can therefore post with no target activity at all.
- R3: `hw_ready` is low while the write queue holds `WQ_DEPTH` entries. A write offered then is not stored, and it never appears on the target side.
- R4: Write entries leave in the order they were accepted.
  - `tw_valid` is high whenever the write queue is non-empty.
  - `{tw_addr, tw_data}` is the oldest entry.
  - The queue advances on `tw_valid && tw_ready`.
  - While `tw_ready` is low, the entry stays stable.
- R5: `tr_req_valid` equals `hr_valid`, and `hr_ready` equals `tr_req_ready`, only when the write queue is empty and `hr_abort` is low. Otherwise both are 0. `tr_req_addr` carries `hr_addr`. A read is released in the cycle after the last queued write drains.
- R6: A cycle with `tw_valid && tw_ready && tw_err` sets `irq` from the next cycle on. If there is no write handshake, `tw_err` has no effect.
- R7: `irq` is sticky. It drops in the cycle after one in which `irq_clr` is high and no new error is reported. An error in the same cycle as `irq_clr` keeps `irq` high.
- R8: A response is stored on `tr_rsp_valid && tr_rsp_ready`. `tr_rsp_ready` is low while the read queue holds `RQ_DEPTH` words, and a response offered then is dropped. `hd_data` presents the words in arrival order.
- R9: `hr_abort` empties the read queue, so `hd_valid` is 0 in the next cycle. A response pushed and a pop made in the abort cycle are both discarded.
- R10: `hd_valid` is high whenever the read queue is non-empty. The head word is removed on `hd_valid && hd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_valid | input | 1 | Host offers a write |
| hw_ready | output | 1 | Write queue has room |
| hw_addr | input | AW | Host write address |
| hw_data | input | DW | Host write data |
| tw_valid | output | 1 | A posted write is waiting for the target |
| tw_ready | input | 1 | Target completes the presented write |
| tw_addr | output | AW | Address of oldest posted write |
| tw_data | output | DW | Data of oldest posted write |
| tw_err | input | 1 | Target reports an error on the completing write |
| irq | output | 1 | Sticky write-error interrupt |
| irq_clr | input | 1 | Host clears the interrupt |
| hr_valid | input | 1 | Host requests a read |
| hr_ready | output | 1 | Read request forwarded this cycle |
| hr_addr | input | AW | Host read address |
| tr_req_valid | output | 1 | Read request toward the target |
| tr_req_ready | input | 1 | Target takes the read request |
| tr_req_addr | output | AW | Read address toward the target |
| tr_rsp_valid | input | 1 | Target returns a read word |
| tr_rsp_ready | output | 1 | Read queue has room |
| tr_rsp_data | input | DW | Returned read word |
| hd_valid | output | 1 | Prefetched word available to the host |
| hd_ready | input | 1 | Host takes the head word |
| hd_data | output | DW | Head prefetched word |
| hr_abort | input | 1 | Host aborts the read; flush the read queue |

## Verification
The hardest state to reach from the ports combines several conditions at once: a full write queue with a read request waiting behind it, and an error arriving on a drain while the host is clearing the interrupt. A directed sequence therefore holds `tw_ready` low to fill the queue past capacity while `hr_valid` stays high. It then drains with `tw_err` raised, and lines up `irq_clr` with a second error. A further directed case aborts a read during a response push and a host pop. After that, random phases with shifting handshake probabilities mix these situations, and a bench queue model checks every output each cycle.

// File: rtl/pwb_pkg.sv
// Shared helpers for the posted-write / prefetch bridge buffer.
// Assumes: depths are at least 1.
package pwb_pkg;

    // Width of a pointer that indexes a queue of the given depth.
    function automatic int ptr_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    // Width of a counter that must hold values 0..depth.
    function automatic int cnt_width(input int depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/pwb_fifo.sv
// Synchronous queue with a single-cycle flush.
// What it does: stores up to DEPTH words and presents the oldest word on rdata.
//   A push is ignored when full and a pop is ignored when empty.
//   Flush empties the queue and overrides any push or pop in the same cycle.
// Assumes: one clock; any DEPTH >= 1 (power of two not required).
module pwb_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int PW = pwb_pkg::ptr_width(DEPTH);
    localparam int CW = pwb_pkg::cnt_width(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] fill;
    logic          do_push, do_pop;

    // Advance a pointer with wrap at DEPTH-1.
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Qualify requests against occupancy and flush.
    always_comb begin
        do_push = push && !full  && !flush;
        do_pop  = pop  && !empty && !flush;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    // Storage write port.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Status and head word.
    always_comb begin
        empty = (fill == '0);
        full  = (fill == CW'(DEPTH));
        rdata = mem[rd_ptr];
    end

endmodule

// File: rtl/pwb_rd_gate.sv
// Read ordering gate.
// What it does: forwards a host read request to the target only while no
//   posted write is pending and no abort is in progress, so a read never
//   overtakes an earlier write and never starts in the flush cycle.
// Assumes: wq_empty comes from a register (no combinational loop).
module pwb_rd_gate #(
    parameter int AW = 16
) (
    input  logic          wq_empty,
    input  logic          abort,
    input  logic          hr_valid,
    input  logic [AW-1:0] hr_addr,
    output logic          hr_ready,
    output logic          tr_req_valid,
    input  logic          tr_req_ready,
    output logic [AW-1:0] tr_req_addr
);
    logic go;

    // Release condition and request pass-through.
    always_comb begin
        go           = wq_empty && !abort;
        tr_req_valid = hr_valid && go;
        hr_ready     = tr_req_ready && go;
        tr_req_addr  = hr_addr;
    end

endmodule

// File: rtl/pwb_err_irq.sv
// Sticky write-error interrupt.
// What it does: sets on an error reported with a completing target write and
//   holds until cleared. A new error in the clear cycle wins over the clear.
// Assumes: wr_done marks a completed target write handshake.
module pwb_err_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_done,
    input  logic wr_err,
    input  logic clr,
    output logic irq
);
    logic set_now;

    // An error only counts together with a completed write.
    always_comb set_now = wr_done && wr_err;

    // Interrupt flag with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= set_now || (irq && !clr);
    end

endmodule

// File: rtl/pwb_bridge_buf.sv
// Posted-write and prefetch bridge buffer (top).
// What it does: queues host writes (address and data together) for in-order
//   draining to the target, and queues read words returned by the target for
//   the host. Reads are gated on an empty write queue, target write errors
//   raise a sticky interrupt, and a host abort flushes the read queue.
// Assumes: host and target sides share clk; front ends are external.
module pwb_bridge_buf #(
    parameter int AW       = 16,
    parameter int DW       = 32,
    parameter int WQ_DEPTH = 4,
    parameter int RQ_DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hw_valid,
    output logic          hw_ready,
    input  logic [AW-1:0] hw_addr,
    input  logic [DW-1:0] hw_data,
    output logic          tw_valid,
    input  logic          tw_ready,
    output logic [AW-1:0] tw_addr,
    output logic [DW-1:0] tw_data,
    input  logic          tw_err,
    output logic          irq,
    input  logic          irq_clr,
    input  logic          hr_valid,
    output logic          hr_ready,
    input  logic [AW-1:0] hr_addr,
    output logic          tr_req_valid,
    input  logic          tr_req_ready,
    output logic [AW-1:0] tr_req_addr,
    input  logic          tr_rsp_valid,
    output logic          tr_rsp_ready,
    input  logic [DW-1:0] tr_rsp_data,
    output logic          hd_valid,
    input  logic          hd_ready,
    output logic [DW-1:0] hd_data,
    input  logic          hr_abort
);
    localparam int EW = AW + DW;

    logic          wq_empty, wq_full, rq_empty, rq_full, wr_done;
    logic [EW-1:0] wq_head;

    // Posted write queue: entry is {address, data}.
    pwb_fifo #(.W(EW), .DEPTH(WQ_DEPTH)) wq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (1'b0),
        .push  (hw_valid),
        .wdata ({hw_addr, hw_data}),
        .pop   (tw_ready),
        .rdata (wq_head),
        .empty (wq_empty),
        .full  (wq_full)
    );

    // Prefetched read data queue, flushed on abort.
    pwb_fifo #(.W(DW), .DEPTH(RQ_DEPTH)) rq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (hr_abort),
        .push  (tr_rsp_valid),
        .wdata (tr_rsp_data),
        .pop   (hd_ready),
        .rdata (hd_data),
        .empty (rq_empty),
        .full  (rq_full)
    );

    // Read request held behind pending writes.
    pwb_rd_gate #(.AW(AW)) gate_i (
        .wq_empty     (wq_empty),
        .abort        (hr_abort),
        .hr_valid     (hr_valid),
        .hr_addr      (hr_addr),
        .hr_ready     (hr_ready),
        .tr_req_valid (tr_req_valid),
        .tr_req_ready (tr_req_ready),
        .tr_req_addr  (tr_req_addr)
    );

    // Error interrupt for already-posted writes.
    pwb_err_irq irq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_done (wr_done),
        .wr_err  (tw_err),
        .clr     (irq_clr),
        .irq     (irq)
    );

    // Port-level status and head split.
    always_comb begin
        hw_ready     = !wq_full;
        tw_valid     = !wq_empty;
        tr_rsp_ready = !rq_full;
        hd_valid     = !rq_empty;
        wr_done      = tw_valid && tw_ready;
        {tw_addr, tw_data} = wq_head;
    end

endmodule

// File: rtl/pwb_bridge_buf_chk.sv
// Port-level checker for the bridge buffer, attached by bind.
// What it does: tracks write-queue occupancy from the handshakes and checks
//   ordering, stall stability, interrupt and flush rules.
// Assumes: synchronous active-low reset shared with the design.
module pwb_bridge_buf_chk #(
    parameter int AW       = 16,
    parameter int DW       = 32,
    parameter int WQ_DEPTH = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hw_valid,
    input logic          hw_ready,
    input logic          tw_valid,
    input logic          tw_ready,
    input logic [AW-1:0] tw_addr,
    input logic [DW-1:0] tw_data,
    input logic          tw_err,
    input logic          irq,
    input logic          irq_clr,
    input logic          tr_req_valid,
    input logic          hd_valid,
    input logic          hr_abort
);
    localparam int CW = pwb_pkg::cnt_width(WQ_DEPTH);

    logic [CW-1:0] wcnt;
    logic          acc, drn;

    // Handshakes seen at the ports.
    always_comb begin
        acc = hw_valid && hw_ready;
        drn = tw_valid && tw_ready;
    end

    // Independent write-queue occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) wcnt <= '0;
        else case ({acc, drn})
            2'b10:   wcnt <= wcnt + 1'b1;
            2'b01:   wcnt <= wcnt - 1'b1;
            default: wcnt <= wcnt;
        endcase
    end

    a_r3_ready_tracks_fill: assert property (@(posedge clk) disable iff (!rst_n)
        hw_ready == (wcnt != CW'(WQ_DEPTH)));

    a_r4_valid_tracks_fill: assert property (@(posedge clk) disable iff (!rst_n)
        tw_valid == (wcnt != '0));

    a_r4_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (tw_valid && !tw_ready) |=> (tw_valid && $stable(tw_addr) && $stable(tw_data)));

    a_r5_read_waits_for_writes: assert property (@(posedge clk) disable iff (!rst_n)
        tw_valid |-> !tr_req_valid);

    a_r5_read_waits_for_flush: assert property (@(posedge clk) disable iff (!rst_n)
        hr_abort |-> !tr_req_valid);

    a_r6_err_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (tw_valid && tw_ready && tw_err) |=> irq);

    a_r7_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    a_r6_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tw_valid && tw_ready && tw_err));

    a_r9_abort_empties: assert property (@(posedge clk) disable iff (!rst_n)
        hr_abort |=> !hd_valid);

endmodule

bind pwb_bridge_buf pwb_bridge_buf_chk #(
    .AW(AW), .DW(DW), .WQ_DEPTH(WQ_DEPTH)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .hw_valid     (hw_valid),
    .hw_ready     (hw_ready),
    .tw_valid     (tw_valid),
    .tw_ready     (tw_ready),
    .tw_addr      (tw_addr),
    .tw_data      (tw_data),
    .tw_err       (tw_err),
    .irq          (irq),
    .irq_clr      (irq_clr),
    .tr_req_valid (tr_req_valid),
    .hd_valid     (hd_valid),
    .hr_abort     (hr_abort)
);

// File: tb/pwb_bridge_buf_tb_top.sv
`timescale 1ns/1ps
// Bench for the bridge buffer: directed corners plus seeded random phases,
// every output compared each cycle with a queue model built from R1..R10.
module pwb_bridge_buf_tb_top;
    localparam int AW  = 16;
    localparam int DW  = 32;
    localparam int WQD = 4;
    localparam int RQD = 4;
    localparam int WATCHDOG = 20000;

    logic clk = 1'b0;
    logic rst_n;
    logic hw_valid, hw_ready, tw_valid, tw_ready, tw_err, irq, irq_clr;
    logic hr_valid, hr_ready, tr_req_valid, tr_req_ready;
    logic tr_rsp_valid, tr_rsp_ready, hd_valid, hd_ready, hr_abort;
    logic [AW-1:0] hw_addr, tw_addr, hr_addr, tr_req_addr;
    logic [DW-1:0] hw_data, tw_data, tr_rsp_data, hd_data;

    int n_chk  = 0;
    int n_fail = 0;

    // Model state.
    logic [AW+DW-1:0] wq_m[$];
    logic [DW-1:0]    rq_m[$];
    logic             m_irq = 1'b0;
    logic             last_set = 1'b0;
    logic             last_abort = 1'b0;

    always #2.5 clk = ~clk;

    pwb_bridge_buf #(.AW(AW), .DW(DW), .WQ_DEPTH(WQD), .RQ_DEPTH(RQD)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .hw_valid(hw_valid), .hw_ready(hw_ready), .hw_addr(hw_addr), .hw_data(hw_data),
        .tw_valid(tw_valid), .tw_ready(tw_ready), .tw_addr(tw_addr), .tw_data(tw_data),
        .tw_err(tw_err), .irq(irq), .irq_clr(irq_clr),
        .hr_valid(hr_valid), .hr_ready(hr_ready), .hr_addr(hr_addr),
        .tr_req_valid(tr_req_valid), .tr_req_ready(tr_req_ready), .tr_req_addr(tr_req_addr),
        .tr_rsp_valid(tr_rsp_valid), .tr_rsp_ready(tr_rsp_ready), .tr_rsp_data(tr_rsp_data),
        .hd_valid(hd_valid), .hd_ready(hd_ready), .hd_data(hd_data),
        .hr_abort(hr_abort)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic pct(input int p);
        return ($urandom % 100) < p;
    endfunction

    // One cycle: drive at negedge, check outputs against model, advance model.
    task automatic do_cycle(input logic hwv, input logic [AW-1:0] ha, input logic [DW-1:0] hdt,
                            input logic twr, input logic twe, input logic clr,
                            input logic hrv, input logic [AW-1:0] hra, input logic trr,
                            input logic rsv, input logic [DW-1:0] rsd,
                            input logic hdr, input logic abt);
        logic w_full, gate, w_acc, w_pop, err, r_push, r_pop;
        @(negedge clk);
        hw_valid = hwv; hw_addr = ha; hw_data = hdt;
        tw_ready = twr; tw_err = twe; irq_clr = clr;
        hr_valid = hrv; hr_addr = hra; tr_req_ready = trr;
        tr_rsp_valid = rsv; tr_rsp_data = rsd; hd_ready = hdr; hr_abort = abt;
        #1;
        w_full = (wq_m.size() == WQD);
        if (w_full) check("R3 hw_ready low when full", hw_ready, 1'b0);
        else        check("R2 hw_ready high with room", hw_ready, 1'b1);
        check("R4 tw_valid", tw_valid, wq_m.size() != 0);
        if (wq_m.size() != 0) check("R4 tw entry order", {tw_addr, tw_data}, wq_m[0]);
        if (last_set) check("R6 irq after error", irq, m_irq);
        else          check("R7 irq sticky/clear", irq, m_irq);
        gate = (wq_m.size() == 0) && !abt;
        check("R5 tr_req_valid", tr_req_valid, hrv && gate);
        check("R5 hr_ready", hr_ready, trr && gate);
        if (hrv && gate) check("R5 tr_req_addr", tr_req_addr, hra);
        check("R8 tr_rsp_ready", tr_rsp_ready, rq_m.size() != RQD);
        if (last_abort) check("R9 hd_valid after abort", hd_valid, rq_m.size() != 0);
        else            check("R10 hd_valid", hd_valid, rq_m.size() != 0);
        if (rq_m.size() != 0) check("R8 hd_data order", hd_data, rq_m[0]);
        // Model update.
        w_acc  = hwv && !w_full;
        w_pop  = (wq_m.size() != 0) && twr;
        err    = w_pop && twe;
        r_push = rsv && (rq_m.size() != RQD);
        r_pop  = hdr && (rq_m.size() != 0);
        if (w_pop) void'(wq_m.pop_front());
        if (w_acc) wq_m.push_back({ha, hdt});
        m_irq = err || (m_irq && !clr);
        last_set = err;
        if (abt) rq_m.delete();
        else begin
            if (r_pop)  void'(rq_m.pop_front());
            if (r_push) rq_m.push_back(rsd);
        end
        last_abort = abt;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) do_cycle(0, '0, '0, 0, 0, 0, 0, '0, 0, 0, '0, 0, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst_n = 1'b0;
        hw_valid = 0; hw_addr = '0; hw_data = '0; tw_ready = 0; tw_err = 0; irq_clr = 0;
        hr_valid = 0; hr_addr = '0; tr_req_ready = 0; tr_rsp_valid = 0; tr_rsp_data = '0;
        hd_ready = 0; hr_abort = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 hw_ready", hw_ready, 1'b1);
        check("R1 tw_valid", tw_valid, 1'b0);
        check("R1 irq", irq, 1'b0);
        check("R1 hd_valid", hd_valid, 1'b0);
        check("R1 tr_rsp_ready", tr_rsp_ready, 1'b1);
        check("R1 tr_req_valid", tr_req_valid, 1'b0);

        // R2/R3/R5: fill write queue with target stalled, read waiting, one extra write.
        for (int i = 0; i < WQD + 1; i++)
            do_cycle(1, AW'(16'h100 + i), DW'(32'hA000 + i), 0, 0, 0, 1, 16'h55, 1, 0, '0, 0, 0);
        // R6: error without handshake has no effect.
        do_cycle(0, '0, '0, 0, 1, 0, 1, 16'h55, 1, 0, '0, 0, 0);
        // R4/R6: drain with an error on the first entry.
        do_cycle(0, '0, '0, 1, 1, 0, 1, 16'h55, 1, 0, '0, 0, 0);
        for (int i = 0; i < WQD - 1; i++)
            do_cycle(0, '0, '0, 1, 0, 0, 1, 16'h55, 1, 0, '0, 0, 0);
        // R5: read released once the queue is empty.
        do_cycle(0, '0, '0, 1, 0, 0, 1, 16'h66, 1, 0, '0, 0, 0);
        // R7: clear coinciding with a new error keeps irq set.
        do_cycle(1, 16'h200, 32'hB0, 0, 0, 0, 0, '0, 0, 0, '0, 0, 0);
        do_cycle(0, '0, '0, 1, 1, 1, 0, '0, 0, 0, '0, 0, 0);
        do_cycle(0, '0, '0, 0, 0, 0, 0, '0, 0, 0, '0, 0, 0);
        do_cycle(0, '0, '0, 0, 0, 1, 0, '0, 0, 0, '0, 0, 0);
        idle(2);
        // R8: fill read queue past capacity, then R9 abort with push and pop.
        for (int i = 0; i < RQD + 1; i++)
            do_cycle(0, '0, '0, 0, 0, 0, 0, '0, 0, 1, DW'(32'hC000 + i), 0, 0);
        do_cycle(0, '0, '0, 0, 0, 0, 1, 16'h77, 1, 1, 32'hDEAD, 1, 1);
        do_cycle(0, '0, '0, 0, 0, 0, 1, 16'h77, 1, 1, 32'hBEEF, 0, 0);
        // R10: pop the surviving word.
        do_cycle(0, '0, '0, 0, 0, 0, 0, '0, 0, 0, '0, 1, 0);
        idle(1);

        // Random phases with shifting handshake probabilities.
        for (int i = 0; i < 4000; i++) begin
            int ph = i / 1000;
            int p_tw = (ph == 0) ? 20 : (ph == 1) ? 80 : 50;
            int p_hd = (ph == 2) ? 15 : 60;
            do_cycle(pct(50), AW'($urandom), DW'($urandom),
                     pct(p_tw), pct(20), pct(10),
                     pct(40), AW'($urandom), pct(70),
                     pct(50), DW'($urandom), pct(p_hd), pct(4));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule